// File: doc/BRIEF.md
# Start/Done Handshake Sequencer with Iterative Accumulator

This block wraps a small multi-cycle arithmetic core in a block-level control handshake. A requester raises `start` with an operand on `din`. The block answers with a one-cycle `ready` when it takes the operand. It drops `idle` while it works. After a fixed number of steps it raises `done`, with the answer on `result`. The core adds `din + k` for every step index `k` from 0 to `N_STEPS-1`, one step per cycle.

Three variants are chosen by parameters:

- **Plain handshake** (`CHAIN=0`): `done` is a single-cycle pulse.
- **Chained** (`CHAIN=1`): `done` and `result` are held until the consumer raises `cont`. This is how a downstream stage applies back-pressure.
- **Free-running** (`FREE_RUN=1`): the handshake is replaced by an unrolled pipeline. It accepts a new operand every cycle.

In both handshake variants, a `start` held high through the `done` cycle launches the next transaction on the following clock, with no idle cycle between them.

Top module: `start_done_seq`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and in the first cycle after it falls, a handshake instance shows `idle`=1, `ready`=0, `done`=0 and `result`=0.
- R2: While `start` stays low, no transaction begins: `idle` stays 1 and `done` stays 0.
- R3: `ready` is 1 in exactly the cycles in which the operand on `din` is taken at the next rising edge. That is a cycle with `start`=1 while idle, or the `done` cycle (in chained mode, only when `cont`=1). In every other cycle `ready` is 0.
- R4: `idle` falls in the cycle after the accepting edge and stays 0 until the transaction leaves its `done` state.
- R5: `done` rises after the (`N_STEPS`+1)-th rising edge counted from the accepting edge, inclusive. `result` then equals the sum over k=0..`N_STEPS`-1 of (`din`+k), modulo 2^`RES_W`, where `RES_W` = `DATA_W` + clog2(`N_STEPS`) + 1.
- R6: With `CHAIN`=0, `done` stays high for exactly one cycle.
- R7: If `start` is high during the `done` cycle, the next transaction is accepted at that edge. `idle` stays 0 throughout, and the next `done` follows `N_STEPS`+1 cycles later.
- R8: The operand is captured on the accepting edge. Changes on `din` during the run do not change `result`.
- R9: With `CHAIN`=1, while `cont` is 0 in the `done` state, `done` stays 1, `result` holds its value and `ready` stays 0 even with `start`=1. A transaction with `start`=1 and `cont`=1 is accepted at the next edge.
- R10: With `FREE_RUN`=1:
  - `idle` is 0 and `ready` is 1 at all times.
  - `done` becomes 1 after `N_STEPS` rising edges out of reset.
  - Each cycle, `result` equals the R5 sum for the `din` that was present `N_STEPS` edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a transaction |
| cont | input | 1 | Downstream permission to leave the done state (chained mode) |
| din | input | DATA_W | Operand word |
| idle | output | 1 | No transaction in progress |
| ready | output | 1 | Operand taken at the next rising edge |
| done | output | 1 | Result is valid |
| result | output | RES_W | Computed sum |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:

- **Done-cycle count.** A design that is off by one step in its counter raises `done` a cycle early or late, and its sum is wrong by one term.
- **Operand changed mid-run.** A design that reads `din` live instead of a captured copy produces a sum of the wrong operand.
- **Back-to-back runs with `start` held high.** A design that returns to idle between transactions shows `idle`=1 for a cycle and delays the second `done`.
- **Chained mode with `cont` low for several cycles while `start` is already high.** A design that ignores back-pressure drops `done`, lets the result change, or asserts `ready` too early.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_HOLD = 2'd2
   } sq_state_e;
endpackage

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
   import sdc_pkg::*;
#(
   parameter int N_STEPS = 4,
   parameter int CHAIN   = 0,
   localparam int CNT_W  = $clog2(N_STEPS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             cont,
   output logic             idle,
   output logic             ready,
   output logic             done,
   output logic             load,
   output logic             run,
   output logic [CNT_W-1:0] step
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(N_STEPS - 1);

   sq_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             release_ok;
   logic             can_take;
   logic             accept;

   generate
      if (CHAIN != 0) begin : g_chain
         assign release_ok = cont;
      end else begin : g_plain
         logic unused_cont;
         assign unused_cont = cont;
         assign release_ok  = 1'b1;
      end
   endgenerate

   assign can_take = (st_q == SQ_IDLE) || ((st_q == SQ_HOLD) && release_ok);
   assign accept   = start && can_take && !rst;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               if (accept) begin
                  st_q  <= SQ_RUN;
                  cnt_q <= '0;
               end
            end
            SQ_RUN: begin
               if (cnt_q == LAST) begin
                  st_q  <= SQ_HOLD;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_HOLD: begin
               if (accept) begin
                  st_q  <= SQ_RUN;
                  cnt_q <= '0;
               end else if (release_ok) begin
                  st_q <= SQ_IDLE;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign idle  = (st_q == SQ_IDLE);
   assign done  = (st_q == SQ_HOLD);
   assign ready = accept;
   assign load  = accept;
   assign run   = (st_q == SQ_RUN);
   assign step  = cnt_q;

   AST_QUIET_STAY_IDLE: assert property (@(posedge clk) disable iff (rst)
      (idle && !start) |=> idle); // R2
   AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
      ready |=> (!idle && !done)); // R4
   AST_NO_READY_MIDRUN: assert property (@(posedge clk) disable iff (rst)
      run |-> !ready); // R3
   generate
      if (CHAIN == 0) begin : g_pulse_chk
         AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            done |=> !done); // R6
      end else begin : g_hold_chk
         AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (rst)
            (done && !cont) |-> !ready); // R9
      end
   endgenerate
endmodule

// File: rtl/sdc_acc.sv
module sdc_acc #(
   parameter int DATA_W  = 8,
   parameter int RES_W   = 11,
   parameter int CNT_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              run,
   input  logic [CNT_W-1:0]  step,
   input  logic [DATA_W-1:0] din,
   output logic [RES_W-1:0]  result
);
   logic [DATA_W-1:0] x_q;
   logic [RES_W-1:0]  acc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q   <= '0;
         acc_q <= '0;
      end else if (load) begin
         x_q   <= din;
         acc_q <= '0;
      end else if (run) begin
         acc_q <= acc_q + RES_W'(x_q) + RES_W'(step);
      end
   end

   assign result = acc_q;

   AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (rst)
      run |=> $stable(x_q)); // R8
endmodule

// File: rtl/sdc_pipe.sv
module sdc_pipe #(
   parameter int DATA_W  = 8,
   parameter int RES_W   = 11,
   parameter int N_STEPS = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din,
   output logic              valid,
   output logic [RES_W-1:0]  result
);
   logic [RES_W-1:0]  part_q [N_STEPS];
   logic [DATA_W-1:0] opnd_q [N_STEPS];
   logic [N_STEPS-1:0] fill_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         part_q[0] <= '0;
         opnd_q[0] <= '0;
         fill_q    <= '0;
      end else begin
         part_q[0] <= RES_W'(din);
         opnd_q[0] <= din;
         fill_q    <= {fill_q[N_STEPS-2:0], 1'b1};
      end
   end

   generate
      for (genvar k = 1; k < N_STEPS; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) begin
               part_q[k] <= '0;
               opnd_q[k] <= '0;
            end else begin
               part_q[k] <= part_q[k-1] + RES_W'(opnd_q[k-1]) + RES_W'(k);
               opnd_q[k] <= opnd_q[k-1];
            end
         end
      end
   endgenerate

   assign valid  = fill_q[N_STEPS-1];
   assign result = part_q[N_STEPS-1];

   AST_FILL_STAYS: assert property (@(posedge clk) disable iff (rst)
      valid |=> valid); // R10
endmodule

// File: rtl/start_done_seq.sv
module start_done_seq #(
   parameter int DATA_W   = 8,
   parameter int N_STEPS  = 4,
   parameter int CHAIN    = 0,
   parameter int FREE_RUN = 0,
   localparam int RES_W   = DATA_W + $clog2(N_STEPS) + 1,
   localparam int CNT_W   = $clog2(N_STEPS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              cont,
   input  logic [DATA_W-1:0] din,
   output logic              idle,
   output logic              ready,
   output logic              done,
   output logic [RES_W-1:0]  result
);
   generate
      if (N_STEPS < 2) begin : g_bad_steps
         $error("start_done_seq: N_STEPS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("start_done_seq: DATA_W must be at least 1");
      end
      if (CHAIN != 0 && CHAIN != 1) begin : g_bad_chain
         $error("start_done_seq: CHAIN must be 0 or 1");
      end
      if (FREE_RUN != 0 && FREE_RUN != 1) begin : g_bad_free
         $error("start_done_seq: FREE_RUN must be 0 or 1");
      end
   endgenerate

   generate
      if (FREE_RUN != 0) begin : g_free
         logic unused_ctl;
         assign unused_ctl = start ^ cont;
         assign idle  = 1'b0;
         assign ready = 1'b1;
         sdc_pipe #(
            .DATA_W (DATA_W),
            .RES_W  (RES_W),
            .N_STEPS(N_STEPS)
         ) u_pipe (
            .clk   (clk),
            .rst   (rst),
            .din   (din),
            .valid (done),
            .result(result)
         );
      end else begin : g_hs
         logic             load;
         logic             run;
         logic [CNT_W-1:0] step;

         sdc_ctrl #(
            .N_STEPS(N_STEPS),
            .CHAIN  (CHAIN)
         ) u_ctrl (
            .clk  (clk),
            .rst  (rst),
            .start(start),
            .cont (cont),
            .idle (idle),
            .ready(ready),
            .done (done),
            .load (load),
            .run  (run),
            .step (step)
         );

         sdc_acc #(
            .DATA_W(DATA_W),
            .RES_W (RES_W),
            .CNT_W (CNT_W)
         ) u_acc (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .run   (run),
            .step  (step),
            .din   (din),
            .result(result)
         );

         AST_RESULT_FROZEN_IN_DONE: assert property (@(posedge clk) disable iff (rst)
            (done && !ready) |=> $stable(result)); // R5
         AST_B2B_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
            (done && ready) |=> (!idle && !done)); // R7
         if (CHAIN != 0) begin : g_hold
            AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
               (done && !cont) |=> (done && $stable(result))); // R9
         end
      end
   endgenerate
endmodule

// File: tb/start_done_seq_tb.sv
module start_done_seq_tb;
   localparam int DW  = 8;
   localparam int NS  = 4;
   localparam int RW  = DW + $clog2(NS) + 1;
   localparam int NV  = 6;
   localparam logic [DW-1:0] VEC [NV] = '{8'd0, 8'd1, 8'd255, 8'd128, 8'd77, 8'd200};

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic start = 0, cont = 0;
   logic [DW-1:0] din = '0;
   logic idle, ready, done;
   logic [RW-1:0] result;

   logic start_c = 0, cont_c = 0;
   logic [DW-1:0] din_c = '0;
   logic idle_c, ready_c, done_c;
   logic [RW-1:0] result_c;

   logic [DW-1:0] din_f = '0;
   logic idle_f, ready_f, done_f;
   logic [RW-1:0] result_f;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   start_done_seq #(.DATA_W(DW), .N_STEPS(NS), .CHAIN(0), .FREE_RUN(0)) u_dut (
      .clk(clk), .rst(rst), .start(start), .cont(cont), .din(din),
      .idle(idle), .ready(ready), .done(done), .result(result));
   start_done_seq #(.DATA_W(DW), .N_STEPS(NS), .CHAIN(1), .FREE_RUN(0)) u_ch (
      .clk(clk), .rst(rst), .start(start_c), .cont(cont_c), .din(din_c),
      .idle(idle_c), .ready(ready_c), .done(done_c), .result(result_c));
   start_done_seq #(.DATA_W(DW), .N_STEPS(NS), .CHAIN(0), .FREE_RUN(1)) u_fr (
      .clk(clk), .rst(rst), .start(1'b0), .cont(1'b0), .din(din_f),
      .idle(idle_f), .ready(ready_f), .done(done_f), .result(result_f));

   function automatic logic [RW-1:0] ref_sum(input logic [DW-1:0] v);
      logic [RW-1:0] s = '0;
      for (int k = 0; k < NS; k++) s = s + RW'(v) + RW'(k);
      return s;
   endfunction

   function automatic logic [DW-1:0] fv(input int n);
      return DW'(n * 37 + 5);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_single(input logic [DW-1:0] v);
      @(negedge clk); start = 1; din = v; #1;
      chk("R3 ready on accept", ready, 1);
      chk("R2 idle before accept", idle, 1);
      @(negedge clk); start = 0; din = ~v; #1;
      chk("R4 idle low", idle, 0);
      chk("R3 ready low midrun", ready, 0);
      for (int j = 2; j <= NS + 1; j++) begin
         @(negedge clk); #1;
         chk("R5 done timing", done, (j == NS + 1));
         chk("R4 idle low in run", idle, 0);
      end
      chk("R5 R8 result", result, ref_sum(v));
      @(negedge clk); #1;
      chk("R6 done single pulse", done, 0);
      chk("R4 idle back", idle, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 idle in reset", idle, 1);
      chk("R1 done in reset", done, 0);
      chk("R1 ready in reset", ready, 0);
      @(negedge clk); rst = 0; #1;
      chk("R1 idle after reset", idle, 1);
      chk("R1 ready after reset", ready, 0);
      chk("R1 result after reset", result, 0);
      chk("R1 chained done after reset", done_c, 0);
      for (int n = 1; n <= NS + 1; n++) begin
         @(negedge clk); #1;
         chk("R2 idle without start", idle, 1);
         chk("R2 done without start", done, 0);
         chk("R10 free-run fill", done_f, (n >= NS));
      end
      chk("R10 free-run ready", ready_f, 1);
      chk("R10 free-run idle", idle_f, 0);

      // table walk: single transactions, R5 R6 R8
      for (int i = 0; i < NV; i++) run_single(VEC[i]);

      // R7 back-to-back with start held high
      @(negedge clk); start = 1; din = 8'd19; #1;
      chk("R7 ready first", ready, 1);
      for (int j = 1; j <= NS + 1; j++) begin
         @(negedge clk);
         if (j == NS + 1) din = 8'd231;
         #1;
         chk("R7 idle stays low", idle, 0);
         chk("R7 done timing 1", done, (j == NS + 1));
      end
      chk("R7 result 1", result, ref_sum(8'd19));
      chk("R7 ready in done cycle", ready, 1);
      for (int j = 1; j <= NS + 1; j++) begin
         @(negedge clk);
         if (j == NS + 1) start = 0;
         #1;
         chk("R7 idle stays low 2", idle, 0);
         chk("R7 done timing 2", done, (j == NS + 1));
      end
      chk("R7 result 2", result, ref_sum(8'd231));
      chk("R3 no ready without start", ready, 0);
      @(negedge clk); #1;
      chk("R7 idle after last", idle, 1);

      // R9 chained back-pressure
      @(negedge clk); start_c = 1; din_c = 8'd90; cont_c = 0; #1;
      chk("R3 chained ready", ready_c, 1);
      @(negedge clk); start_c = 0; din_c = 8'd0; #1;
      for (int j = 2; j <= NS + 1; j++) begin
         @(negedge clk); #1;
         chk("R5 chained done timing", done_c, (j == NS + 1));
      end
      chk("R5 chained result", result_c, ref_sum(8'd90));
      for (int j = 1; j <= 3; j++) begin
         @(negedge clk);
         if (j == 2) begin start_c = 1; din_c = 8'd44; end
         #1;
         chk("R9 done held", done_c, 1);
         chk("R9 result held", result_c, ref_sum(8'd90));
         chk("R9 no ready while held", ready_c, 0);
      end
      @(negedge clk); cont_c = 1; #1;
      chk("R9 ready with cont", ready_c, 1);
      chk("R9 done still high", done_c, 1);
      @(negedge clk); cont_c = 0; start_c = 0; #1;
      chk("R9 accepted", done_c, 0);
      chk("R9 idle low after accept", idle_c, 0);
      for (int j = 2; j <= NS + 1; j++) begin
         @(negedge clk); #1;
         chk("R9 second done timing", done_c, (j == NS + 1));
      end
      chk("R9 second result", result_c, ref_sum(8'd44));
      @(negedge clk); cont_c = 1; #1;
      chk("R9 done till cont sampled", done_c, 1);
      @(negedge clk); cont_c = 0; #1;
      chk("R9 release to idle", idle_c, 1);
      chk("R9 done released", done_c, 0);

      // R10 free-running pipeline
      for (int n = 0; n < 12; n++) begin
         @(negedge clk); din_f = fv(n); #1;
         if (n >= NS) chk("R10 free-run result", result_f, ref_sum(fv(n - NS)));
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule